// File: doc/BRIEF.md
# Dual 5x7 Matrix Column Scanner

This block multiplexes two five-column dot-matrix panels, ten columns in all, that share one set of eight active-low row lines. The columns are selected by an external serial column shift register: the scanner clocks that register once per column and feeds it a single token bit at the start of each frame. The token then walks along the shift register, lighting one column at a time. After every clock pulse the scanner puts the pattern for the newly selected column on the row lines.

Column patterns come from a small built-in glyph store holding eight glyphs of five bytes each, one glyph every eight addresses. A control block supplies two start addresses, one per panel. The right panel is scanned first, starting at the right start address. The left panel follows, starting at the left start address. The left panel is mounted mirrored, so its bytes are bit-reversed before they reach the row lines. This lets one glyph set serve both panels. A free-running tick enable sets the pace: one column per eight ticks.

Top module: `dual_matrix_scanner`

## Requirements
- R1: While reset is held and for exactly one clock cycle after it is released, `col_clr_n` is low. After that it stays high. During reset `row_n` is all ones, `col_clk` is high and `col_data` is low.
- R2: A column step begins on the clock edge at which the eighth `tick_en` since the previous step (or since reset) is sampled high. Cycles with `tick_en` low never start a step and leave `row_n` unchanged.
- R3: Each column step drives `col_clk` low for exactly one cycle and then high again. Steps produce no other `col_clk` activity.
- R4: `col_data` is high during the clock pulse of column 0 only. It is low during every other column's pulse and low again in the cycle after the pulse completes.
- R5: At column 0 the read address loads from `right_base`. Columns 0 to 4 show the stored byte at `right_base + k` (k = 0..4, address arithmetic modulo 64), unchanged.
- R6: At column 5 the read address loads from `left_base`. Columns 5 to 9 show the byte at `left_base + k` (k = 0..4) with its bits reversed (bit 0 becomes bit 7).
- R7: The store returns, for glyph g at address 8g + r with r in 0..4: g0 = FF FF 80 FF FF, g1 = E3 C1 C1 C1 E3, g2 = E3 DD DD DD DD, g3 = F7 FB C0 FB F7, g4 = FC FB F7 EF DF, g5 = DF EF F7 FB FC, g6 = all FF, g7 = all 80. Offsets r = 5..7 return FF.
- R8: `row_n` changes only in the cycle after the rising edge of a step's `col_clk` pulse, and holds its value until the next step.
- R9: A change of `right_base` after column 0 has loaded, or of `left_base` after column 5 has loaded, has no effect on the remaining columns of that panel in the current frame.
- R10: After column 9 the index wraps to column 0. The next frame again sends a token bit and reloads from `right_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Scan pacing enable, one pulse per tick |
| right_base | input | 6 | Start address of the right panel's glyph |
| left_base | input | 6 | Start address of the left panel's glyph |
| col_clk | output | 1 | Clock to the external column shift register |
| col_data | output | 1 | Serial token input of the column shift register |
| col_clr_n | output | 1 | Active-low clear of the column shift register |
| row_n | output | 8 | Active-low row pattern for the selected column |

## Verification
The bench goes after the panel boundary. A scanner that reverses the wrong half, or loads the left address one column early or late, shows a mirrored or shifted glyph on columns 4 to 6. Start addresses that are not glyph-aligned and wrap past address 63 expose an address counter that is too narrow, as well as the FF padding rows. Base addresses changed in the middle of a panel catch a design that reads the start address on every column instead of loading it once. Sparse and dense tick patterns, the second-frame token and a quiet stretch with no ticks catch a miscounted divider, a token sent on every column, or a column wrap at the wrong count.

// File: rtl/scan_pkg.sv
package scan_pkg;

   typedef enum logic [1:0] {
      SEQ_CLR  = 2'd0,
      SEQ_IDLE = 2'd1,
      SEQ_LOW  = 2'd2,
      SEQ_HIGH = 2'd3
   } seq_state_e;

   // Glyph bytes: g selects the glyph, r the column within it.
   function automatic logic [7:0] glyph_byte(input logic [2:0] g, input logic [2:0] r);
      logic [7:0] b;
      b = 8'hFF;
      if (r < 3'd5) begin
         case (g)
            3'd0: b = (r == 3'd2) ? 8'h80 : 8'hFF;
            3'd1: b = (r == 3'd0 || r == 3'd4) ? 8'hE3 : 8'hC1;
            3'd2: b = (r == 3'd0) ? 8'hE3 : 8'hDD;
            3'd3: begin
               case (r)
                  3'd0, 3'd4: b = 8'hF7;
                  3'd1, 3'd3: b = 8'hFB;
                  default:    b = 8'hC0;
               endcase
            end
            3'd4: begin
               case (r)
                  3'd0:    b = 8'hFC;
                  3'd1:    b = 8'hFB;
                  3'd2:    b = 8'hF7;
                  3'd3:    b = 8'hEF;
                  default: b = 8'hDF;
               endcase
            end
            3'd5: begin
               case (r)
                  3'd0:    b = 8'hDF;
                  3'd1:    b = 8'hEF;
                  3'd2:    b = 8'hF7;
                  3'd3:    b = 8'hFB;
                  default: b = 8'hFC;
               endcase
            end
            3'd6:    b = 8'hFF;
            default: b = 8'h80;
         endcase
      end
      return b;
   endfunction

endpackage

// File: rtl/scan_tick_div.sv
module scan_tick_div #(
   parameter int TICKS_PER_STEP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   output logic step
);
   localparam int CNT_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_STEP - 1);

   logic [CNT_W-1:0] cnt_q;

   assign step = tick_en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_en) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/scan_glyph_rom.sv
module scan_glyph_rom #(
   parameter int ADDR_W = 6,
   parameter int ROW_W  = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ROW_W-1:0]  data
);
   import scan_pkg::*;

   logic in_range;

   generate
      if (ADDR_W == 6) begin : g_exact
         assign in_range = 1'b1;
      end else begin : g_wide
         assign in_range = (addr[ADDR_W-1:6] == '0);
      end
   endgenerate

   always_comb begin
      data = '1;
      if (in_range) begin
         data = ROW_W'(glyph_byte(addr[5:3], addr[2:0]));
      end
   end
endmodule

// File: rtl/scan_row_order.sv
module scan_row_order #(
   parameter int ROW_W  = 8,
   parameter bit MIRROR = 1'b1
) (
   input  logic             mirror_sel,
   input  logic [ROW_W-1:0] din,
   output logic [ROW_W-1:0] dout
);
   generate
      if (MIRROR) begin : g_mirror
         logic [ROW_W-1:0] rev;
         for (genvar i = 0; i < ROW_W; i++) begin : g_bit
            assign rev[i] = din[ROW_W-1-i];
         end
         assign dout = mirror_sel ? rev : din;
      end else begin : g_plain
         logic unused_sel;
         assign unused_sel = mirror_sel;
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/dual_matrix_scanner.sv
module dual_matrix_scanner #(
   parameter int ADDR_W         = 6,
   parameter int ROW_W          = 8,
   parameter int COLS_PER_PANEL = 5,
   parameter int TICKS_PER_STEP = 8,
   parameter bit MIRROR_LEFT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] right_base,
   input  logic [ADDR_W-1:0] left_base,
   output logic              col_clk,
   output logic              col_data,
   output logic              col_clr_n,
   output logic [ROW_W-1:0]  row_n
);
   import scan_pkg::*;

   localparam int NUM_COLS = 2 * COLS_PER_PANEL;
   localparam int COL_W    = $clog2(NUM_COLS);
   localparam logic [COL_W-1:0] COL_LEFT = COL_W'(COLS_PER_PANEL);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

   generate
      if (TICKS_PER_STEP < 4) begin : g_bad_ticks
         $error("TICKS_PER_STEP must cover the three-cycle step sequence");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must reach all glyph addresses");
      end
      if (ROW_W != 8) begin : g_bad_row
         $error("ROW_W must match the glyph byte width");
      end
      if (COLS_PER_PANEL < 1 || COLS_PER_PANEL > 8) begin : g_bad_cols
         $error("COLS_PER_PANEL out of range");
      end
   endgenerate

   seq_state_e        state_q;
   logic [COL_W-1:0]  col_q;
   logic [ADDR_W-1:0] addr_q;
   logic              step;
   logic [ROW_W-1:0]  rom_byte;
   logic [ROW_W-1:0]  ordered;

   scan_tick_div #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .step    (step)
   );

   scan_glyph_rom #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_rom (
      .addr (addr_q),
      .data (rom_byte)
   );

   scan_row_order #(.ROW_W(ROW_W), .MIRROR(MIRROR_LEFT)) u_order (
      .mirror_sel (col_q >= COL_LEFT),
      .din        (rom_byte),
      .dout       (ordered)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_CLR;
         col_q     <= '0;
         addr_q    <= '0;
         col_clk   <= 1'b1;
         col_data  <= 1'b0;
         col_clr_n <= 1'b0;
         row_n     <= '1;
      end else begin
         case (state_q)
            SEQ_CLR: begin
               col_clr_n <= 1'b1;
               state_q   <= SEQ_IDLE;
            end
            SEQ_IDLE: begin
               if (step) begin
                  col_clk <= 1'b0;
                  if (col_q == '0) begin
                     col_data <= 1'b1;
                     addr_q   <= right_base;
                  end
                  if (col_q == COL_LEFT) begin
                     addr_q <= left_base;
                  end
                  state_q <= SEQ_LOW;
               end
            end
            SEQ_LOW: begin
               col_clk <= 1'b1;
               state_q <= SEQ_HIGH;
            end
            default: begin
               col_data <= 1'b0;
               row_n    <= ordered;
               addr_q   <= addr_q + 1'b1;
               col_q    <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
               state_q  <= SEQ_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/dual_matrix_scanner_chk.sv
module dual_matrix_scanner_chk #(
   parameter int ROW_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             col_clk,
   input logic             col_data,
   input logic             col_clr_n,
   input logic [ROW_W-1:0] row_n
);
   // R1
   clr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !col_clr_n |=> col_clr_n);

   // R3
   clk_low_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !col_clk |=> col_clk);

   // R2
   step_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(col_clk) |-> $past(tick_en));

   // R4
   token_during_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_data && !col_clk) |=> (col_data && col_clk));

   // R4
   token_drops_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_data && col_clk) |=> !col_data);

   // R8
   row_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_n) |-> ($past(col_clk) && !$past(col_clk, 2)));
endmodule

bind dual_matrix_scanner dual_matrix_scanner_chk #(.ROW_W(ROW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .col_clk   (col_clk),
   .col_data  (col_data),
   .col_clr_n (col_clr_n),
   .row_n     (row_n)
);

// File: tb/dual_matrix_scanner_bench.sv
`timescale 1ns/1ps
module dual_matrix_scanner_bench;

   typedef struct {
      logic [7:0] row;
      logic       tok;
      int         col;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [5:0] right_base = '0;
   logic [5:0] left_base = '0;
   logic       col_clk, col_data, col_clr_n;
   logic [7:0] row_n;

   int checks = 0;
   int fails = 0;
   int tick_total = 0;
   int tick_at_step = 0;
   bit finished = 1'b0;
   exp_t expq[$];

   always #2 clk = ~clk;

   dual_matrix_scanner u_dual_matrix_scanner (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .right_base(right_base), .left_base(left_base),
      .col_clk(col_clk), .col_data(col_data), .col_clr_n(col_clr_n),
      .row_n(row_n)
   );

   always @(posedge clk) if (rst_n && tick_en) tick_total <= tick_total + 1;

   function automatic logic [7:0] model_byte(input logic [5:0] a);
      logic [7:0] g [8][5];
      g[0] = '{8'hFF, 8'hFF, 8'h80, 8'hFF, 8'hFF};
      g[1] = '{8'hE3, 8'hC1, 8'hC1, 8'hC1, 8'hE3};
      g[2] = '{8'hE3, 8'hDD, 8'hDD, 8'hDD, 8'hDD};
      g[3] = '{8'hF7, 8'hFB, 8'hC0, 8'hFB, 8'hF7};
      g[4] = '{8'hFC, 8'hFB, 8'hF7, 8'hEF, 8'hDF};
      g[5] = '{8'hDF, 8'hEF, 8'hF7, 8'hFB, 8'hFC};
      g[6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
      g[7] = '{8'h80, 8'h80, 8'h80, 8'h80, 8'h80};
      if (a[2:0] > 3'd4) return 8'hFF;
      return g[a[5:3]][a[2:0]];
   endfunction

   function automatic logic [7:0] flip(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Driver: queue one frame's expectations, then issue its ticks.
   task automatic run_frame(input logic [5:0] rb, input logic [5:0] lb,
                            input int gap, input bit disturb);
      @(negedge clk);
      right_base = rb;
      left_base  = lb;
      for (int k = 0; k < 10; k++) begin
         exp_t e;
         e.col = k;
         e.tok = (k == 0);
         if (k < 5) e.row = model_byte(rb + 6'(k));      // R5
         else       e.row = flip(model_byte(lb + 6'(k - 5))); // R6
         expq.push_back(e);
      end
      for (int t = 1; t <= 80; t++) begin
         @(negedge clk);
         tick_en = 1'b1;
         @(negedge clk);
         tick_en = 1'b0;
         for (int g = 0; g < gap; g++) @(negedge clk);
         if (disturb && t == 16) right_base = rb ^ 6'h3F; // R9
         if (disturb && t == 56) left_base  = lb ^ 6'h3F; // R9
      end
   endtask

   // Monitor: one pulse per step, pops and compares.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && col_clk === 1'b0) begin
            exp_t e;
            logic tok;
            tok = col_data;
            check((tick_total - tick_at_step) == 8, "R2", tick_total - tick_at_step, 8);
            tick_at_step = tick_total;
            @(negedge clk);
            check(col_clk === 1'b1, "R3", col_clk, 1);
            @(negedge clk);
            check(col_data === 1'b0, "R4", col_data, 0);
            if (expq.size() == 0) begin
               check(1'b0, "R2 unexpected step", 1, 0);
            end else begin
               e = expq.pop_front();
               check(tok === e.tok, e.tok ? "R10/R4 token" : "R4 token", tok, e.tok);
               check(row_n === e.row, (e.col < 5) ? "R5/R7 row" : "R6/R7 row", row_n, e.row);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] held;
      repeat (3) @(negedge clk);
      check(row_n === 8'hFF, "R1 rows", row_n, 8'hFF);
      check(col_clk === 1'b1, "R1 clk", col_clk, 1);
      check(col_data === 1'b0, "R1 data", col_data, 0);
      check(col_clr_n === 1'b0, "R1 clr", col_clr_n, 0);
      rst_n = 1'b1;
      #0 check(col_clr_n === 1'b0, "R1 clr held", col_clr_n, 0);
      @(negedge clk);
      check(col_clr_n === 1'b1, "R1 clr release", col_clr_n, 1);
      run_frame(6'h08, 6'h38, 0, 1'b0);
      run_frame(6'h18, 6'h20, 2, 1'b0);
      run_frame(6'h28, 6'h10, 1, 1'b1);
      run_frame(6'h3D, 6'h05, 0, 1'b0);
      repeat (12) @(negedge clk);
      held = row_n;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         check(row_n === held && col_clk === 1'b1, "R2 idle", row_n, held);
      end
      check(expq.size() == 0, "R8 steps drained", expq.size(), 0);
      check(col_clr_n === 1'b1, "R1 clr stays high", col_clr_n, 1);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule